// File: doc/BRIEF.md
# Banked Binary Point Register Slice

This block is the binary point portion of an interrupt controller's per-processor interface. Each CPU owns a primary binary point value, a separate copy used by non-secure software, and a small control word. The control word carries a common-binary-point enable. Software reaches the block over a simple register bus. An access carries a secure attribute, a CPU index and an offset, and completes one cycle after it is presented.

When the security extension is built in, secure and non-secure accesses see different values. While a CPU's common-binary-point bit is set, its non-secure view becomes derived rather than stored. A read returns the primary value plus one, capped at 7, and a write is dropped without any error. Without the extension, every access goes to the primary value. Every written value is cut to three bits and raised to a floor, and the secure and non-secure floors are separate.

The access control is a two-state machine. ST_IDLE moves to ST_ACK when valid is seen. ST_IDLE stays in ST_IDLE otherwise. ST_ACK stays in ST_ACK when a new valid request arrives, which allows back-to-back accesses. ST_ACK returns to ST_IDLE otherwise. Ready is high exactly while the machine is in ST_ACK.

Top module: `bpr_bank_regs`

## Requirements
- R1: After reset, every CPU's primary value equals MIN_SEC (default 2), every non-secure copy equals MIN_NS (default MIN_SEC+1), every control word reads 0, and ready is low.
- R2: An access presented with valid in one cycle gets ready high in the next cycle only. A write response carries read data 0.
- R3: With the security extension, a secure access at offset 0x08 reads or writes that CPU's primary value.
- R4: With the security extension and control bit 4 clear, a non-secure access at offset 0x08 reads or writes that CPU's separate non-secure copy. The primary value is not changed.
- R5: A write to a binary point keeps data bits [2:0] and raises them to the floor of the target: MIN_SEC for the primary value, MIN_NS for the non-secure copy.
- R6: With the security extension and control bit 4 set, a non-secure read at 0x08 returns min(primary + 1, 7).
- R7: With the security extension and control bit 4 set, a non-secure write at 0x08 still gets ready. Neither stored value changes.
- R8: Offset 0x00 holds a per-CPU control word of bits [4:0], written from data bits [4:0]. Bit 4 is the common-binary-point enable. All read data is zero-extended to 32 bits.
- R9: All stored state is per CPU and is selected by the access's CPU index. A write to one CPU leaves the others unchanged.
- R10: An offset other than 0x00 and 0x08 reads 0, and a write to it changes no state.
- R11: Without the security extension, every access at 0x08 reads or writes the primary value with the MIN_SEC floor, whatever the secure attribute and control bit 4 are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Secure attribute of the access |
| req_cpu | input | CPU_W | CPU index selecting the register bank |
| req_offset | input | OFF_W | Byte offset within the interface map |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid while rsp_ready is high |
| rsp_ready | output | 1 | Access complete, one cycle after valid |

## Verification
The checker assertions hold on every cycle. They cover the one-cycle ready timing, zero read data on write responses and on unimplemented offsets, zero upper read bits, and the MIN_SEC floor on secure binary point reads. The banked behaviour depends on stored history, so only the bench's scenarios can show it. That includes the incremented and saturated non-secure view, dropped non-secure writes under the common bit, the separate non-secure floor, and isolation between CPUs. A second instance built without the security extension runs the same traffic. Its checks confirm that the secure attribute and the common bit have no effect there.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

    localparam int DATA_W    = 32;
    localparam int BP_W      = 3;
    localparam int CTRL_W    = 5;
    localparam int CBPR_BIT  = 4;
    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_BP    = 'h08;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } acc_state_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [BP_W-1:0]   sec_bp;
        logic [BP_W-1:0]   ns_bp;
    } cpu_state_t;

    function automatic logic [BP_W-1:0] clamp_bp(input logic [BP_W-1:0] raw,
                                                 input logic [BP_W-1:0] floor_v);
        return (raw < floor_v) ? floor_v : raw;
    endfunction

endpackage

// File: rtl/bpr_access_fsm.sv
module bpr_access_fsm
    import bpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] rd_value,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata
);

    acc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_ACK : ST_IDLE;
            ST_ACK:  state_d = req_valid ? ST_ACK : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (req_valid) begin
            rsp_rdata <= req_write ? '0 : rd_value;
        end
    end

    assign rsp_ready = (state_q == ST_ACK);

endmodule

// File: rtl/bpr_cpu_slice.sv
module bpr_cpu_slice
    import bpr_pkg::*;
#(
    parameter int MIN_SEC = 2,
    parameter int MIN_NS  = MIN_SEC + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_sec,
    input  logic              wr_ns,
    input  logic [CTRL_W-1:0] wdata_lo,
    output cpu_state_t        state_q
);

    localparam logic [BP_W-1:0] SEC_FLOOR = BP_W'(MIN_SEC);
    localparam logic [BP_W-1:0] NS_FLOOR  = BP_W'(MIN_NS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ctrl   <= '0;
            state_q.sec_bp <= SEC_FLOOR;
            state_q.ns_bp  <= NS_FLOOR;
        end else begin
            if (wr_ctrl) state_q.ctrl   <= wdata_lo;
            if (wr_sec)  state_q.sec_bp <= clamp_bp(wdata_lo[BP_W-1:0], SEC_FLOOR);
            if (wr_ns)   state_q.ns_bp  <= clamp_bp(wdata_lo[BP_W-1:0], NS_FLOOR);
        end
    end

endmodule

// File: rtl/bpr_view.sv
module bpr_view
    import bpr_pkg::*;
#(
    parameter bit SEC_EXT = 1'b1,
    parameter int OFF_W   = 8
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_secure,
    input  logic [OFF_W-1:0]  acc_offset,
    input  cpu_state_t        cur,
    output logic [DATA_W-1:0] rd_value,
    output logic              wr_ctrl,
    output logic              wr_sec,
    output logic              wr_ns
);

    logic            is_ctrl, is_bp, do_wr;
    logic [BP_W-1:0] bp_view;

    assign is_ctrl = (acc_offset == OFF_W'(OFF_CTRL));
    assign is_bp   = (acc_offset == OFF_W'(OFF_BP));
    assign do_wr   = acc_valid & acc_write;
    assign wr_ctrl = do_wr & is_ctrl;

    generate
        if (SEC_EXT) begin : g_banked
            logic            common_bp;
            logic [BP_W-1:0] sec_plus;
            assign common_bp = cur.ctrl[CBPR_BIT];
            assign sec_plus  = (cur.sec_bp == {BP_W{1'b1}}) ? cur.sec_bp
                                                            : cur.sec_bp + 1'b1;
            always_comb begin
                if (acc_secure)     bp_view = cur.sec_bp;
                else if (common_bp) bp_view = sec_plus;
                else                bp_view = cur.ns_bp;
            end
            assign wr_sec = do_wr & is_bp & acc_secure;
            assign wr_ns  = do_wr & is_bp & ~acc_secure & ~common_bp;
        end else begin : g_flat
            assign bp_view = cur.sec_bp;
            assign wr_sec  = do_wr & is_bp;
            assign wr_ns   = 1'b0;
        end
    endgenerate

    always_comb begin
        rd_value = '0;
        if (is_ctrl)    rd_value = DATA_W'(cur.ctrl);
        else if (is_bp) rd_value = DATA_W'(bp_view);
    end

endmodule

// File: rtl/bpr_bank_regs.sv
module bpr_bank_regs
    import bpr_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter bit SEC_EXT = 1'b1,
    parameter int MIN_SEC = 2,
    parameter int MIN_NS  = MIN_SEC + 1,
    parameter int OFF_W   = 8,
    parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_ready
);

    cpu_state_t        bank [NUM_CPU];
    cpu_state_t        cur;
    logic              cpu_ok;
    logic [DATA_W-1:0] rd_value;
    logic              wr_ctrl, wr_sec, wr_ns;

    assign cpu_ok = (32'(req_cpu) < NUM_CPU);

    always_comb begin
        cur = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (req_cpu == CPU_W'(i)) cur = bank[i];
        end
    end

    bpr_view #(
        .SEC_EXT (SEC_EXT),
        .OFF_W   (OFF_W)
    ) u_view (
        .acc_valid  (req_valid & cpu_ok),
        .acc_write  (req_write),
        .acc_secure (req_secure),
        .acc_offset (req_offset),
        .cur        (cur),
        .rd_value   (rd_value),
        .wr_ctrl    (wr_ctrl),
        .wr_sec     (wr_sec),
        .wr_ns      (wr_ns)
    );

    generate
        for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
            logic hit;
            assign hit = (req_cpu == CPU_W'(g));
            bpr_cpu_slice #(
                .MIN_SEC (MIN_SEC),
                .MIN_NS  (MIN_NS)
            ) u_slice (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_ctrl  (wr_ctrl & hit),
                .wr_sec   (wr_sec & hit),
                .wr_ns    (wr_ns & hit),
                .wdata_lo (req_wdata[CTRL_W-1:0]),
                .state_q  (bank[g])
            );
        end
    endgenerate

    bpr_access_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .rd_value  (rd_value),
        .rsp_ready (rsp_ready),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/bpr_bank_sva.sv
module bpr_bank_sva #(
    parameter int MIN_SEC = 2,
    parameter int OFF_W   = 8,
    parameter int CPU_W   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             req_secure,
    input logic [CPU_W-1:0] req_cpu,
    input logic [OFF_W-1:0] req_offset,
    input logic [31:0]      rsp_rdata,
    input logic             rsp_ready
);

    logic unimpl;
    assign unimpl = (req_offset != OFF_W'('h00)) && (req_offset != OFF_W'('h08));

    a_r2_ready_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ready);

    a_r2_no_spurious_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ready);

    a_r2_write_resp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == 32'd0));

    a_r10_unimpl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && unimpl) |=> (rsp_rdata == 32'd0));

    a_r8_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (rsp_rdata[31:5] == '0));

    a_r5_secure_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_secure && req_offset == OFF_W'('h08))
        |=> (rsp_rdata >= 32'(MIN_SEC)));

    logic unused_cpu;
    assign unused_cpu = ^req_cpu;

endmodule

bind bpr_bank_regs bpr_bank_sva #(
    .MIN_SEC (MIN_SEC),
    .OFF_W   (OFF_W),
    .CPU_W   (CPU_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_secure (req_secure),
    .req_cpu    (req_cpu),
    .req_offset (req_offset),
    .rsp_rdata  (rsp_rdata),
    .rsp_ready  (rsp_ready)
);

// File: tb/tb_bpr_bank_regs.sv
module tb_bpr_bank_regs;

    localparam int NCPU  = 4;
    localparam int MSEC  = 2;
    localparam int MNS   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [1:0]  req_cpu = '0;
    logic [7:0]  req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rdata, rdata_f;
    logic        ready, ready_f;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int sec_m [NCPU];
    int ns_m  [NCPU];
    int ctl_m [NCPU];
    int fbp_m [NCPU];
    int fctl_m[NCPU];

    always #2 clk = ~clk;

    bpr_bank_regs #(.NUM_CPU(NCPU), .SEC_EXT(1'b1), .MIN_SEC(MSEC), .MIN_NS(MNS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_cpu(req_cpu), .req_offset(req_offset),
        .req_wdata(req_wdata), .rsp_rdata(rdata), .rsp_ready(ready));

    bpr_bank_regs #(.NUM_CPU(NCPU), .SEC_EXT(1'b0), .MIN_SEC(MSEC), .MIN_NS(MNS)) dut_flat (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_cpu(req_cpu), .req_offset(req_offset),
        .req_wdata(req_wdata), .rsp_rdata(rdata_f), .rsp_ready(ready_f));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int clampv(input int d, input int fl);
        int v = d & 7;
        return (v < fl) ? fl : v;
    endfunction

    task automatic access(input bit wr, input bit sec, input int cpu, input int off,
                          input logic [31:0] d, input string tag);
        logic [31:0] e1, e2;
        e1 = 0; e2 = 0;
        if (!wr) begin
            if (off == 0) begin
                e1 = ctl_m[cpu]; e2 = fctl_m[cpu];
            end else if (off == 8) begin
                e2 = fbp_m[cpu];
                if (sec)                 e1 = sec_m[cpu];
                else if (ctl_m[cpu][4])  e1 = (sec_m[cpu] + 1 > 7) ? 7 : sec_m[cpu] + 1;
                else                     e1 = ns_m[cpu];
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_secure = sec;
        req_cpu = 2'(cpu); req_offset = 8'(off); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " ready"}, 32'(ready), 32'd1);
        chk({tag, " rdata"}, rdata, e1);
        chk("R11 flat rdata", rdata_f, e2);
        if (wr) begin
            if (off == 0) begin
                ctl_m[cpu] = d & 32'h1F; fctl_m[cpu] = d & 32'h1F;
            end else if (off == 8) begin
                fbp_m[cpu] = clampv(d, MSEC);
                if (sec)                 sec_m[cpu] = clampv(d, MSEC);
                else if (!ctl_m[cpu][4]) ns_m[cpu]  = clampv(d, MNS);
            end
        end
        @(negedge clk);
        chk("R2 ready drops", 32'(ready), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < NCPU; i++) begin
            sec_m[i] = MSEC; ns_m[i] = MNS; ctl_m[i] = 0; fbp_m[i] = MSEC; fctl_m[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", 32'(ready), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(ready), 32'd0);

        for (int c = 0; c < NCPU; c++) begin
            access(0, 1, c, 8, 0, "R1 secure bp reset");
            access(0, 0, c, 8, 0, "R1 ns bp reset");
            access(0, 1, c, 0, 0, "R1 ctrl reset");
        end

        for (int c = 0; c < NCPU; c++)
            for (int v = 0; v < 8; v++) begin
                access(1, 1, c, 8, 32'hABCD_0000 | 32'(v) | 32'h10, "R5 secure write");
                access(0, 1, c, 8, 0, "R3 R5 secure read");
            end

        for (int c = 0; c < NCPU; c++)
            for (int v = 0; v < 8; v++) begin
                access(1, 0, c, 8, 32'(v) | 32'hF8, "R4 ns write");
                access(0, 0, c, 8, 0, "R4 R5 ns read");
                access(0, 1, c, 8, 0, "R4 primary untouched");
            end

        for (int c = 0; c < NCPU; c++) begin
            access(1, 0, c, 0, 32'hFFFF_FFE0 | 32'(5 + c), "R8 ctrl write");
            access(0, 1, c, 0, 0, "R8 ctrl read");
            access(1, 1, c, 0, 32'h0000_0010, "R8 set common bit");
        end

        for (int c = 0; c < NCPU; c++)
            for (int v = 0; v < 8; v++) begin
                access(1, 1, c, 8, 32'(v), "R6 secure write");
                access(0, 0, c, 8, 0, "R6 ns derived read");
            end

        for (int c = 0; c < NCPU; c++) begin
            access(1, 1, c, 8, 32'd4, "R7 secure setup");
            access(1, 0, c, 8, 32'd6, "R7 ns write dropped");
            access(0, 1, c, 8, 0, "R7 primary unchanged");
            access(1, 1, c, 0, 32'd0, "R7 clear common bit");
            access(0, 0, c, 8, 0, "R7 ns copy unchanged");
        end

        access(1, 1, 0, 0, 32'h10, "R9 common on cpu0");
        for (int c = 0; c < NCPU; c++) access(1, 1, c, 8, 32'(3 + c), "R9 distinct write");
        for (int c = 0; c < NCPU; c++) begin
            access(0, 1, c, 8, 0, "R9 per cpu primary");
            access(0, 0, c, 8, 0, "R9 per cpu ns view");
            access(0, 1, c, 0, 0, "R9 per cpu ctrl");
        end

        for (int k = 0; k < 4; k++) begin
            int off;
            off = (k == 0) ? 'h04 : (k == 1) ? 'h0C : (k == 2) ? 'h10 : 'hFC;
            access(1, 1, 1, off, 32'hFFFF_FFFF, "R10 unimpl write");
            access(1, 0, 1, off, 32'hFFFF_FFFF, "R10 unimpl ns write");
            access(0, 1, 1, off, 0, "R10 unimpl read");
            access(0, 1, 1, 8, 0, "R10 bp untouched");
            access(0, 0, 1, 8, 0, "R10 ns untouched");
            access(0, 1, 1, 0, 0, "R10 ctrl untouched");
        end

        access(1, 0, 2, 8, 32'd0, "R11 ns write floor");
        access(0, 0, 2, 8, 0, "R11 ns read");
        access(0, 1, 2, 8, 0, "R11 secure read");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL R2 watchdog: actual no completion expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule